// File: doc/BRIEF.md
# Page Permission and Reference Checker

The block decides whether one memory access may use a leaf translation entry that has already been located. Each request carries the 64-bit leaf entry and the kind of access: load, store or instruction fetch. It also carries the problem-state bit, a flag saying the access runs under a privileged translation index, a flag saying the check belongs to the partition-scoped stage, and a 3-bit mask taken from the authority mask register. From these the block works out the read/write/execute rights that the entry grants. It then reports whether the access is refused and why.

The checks run in a fixed order. A fetch from non-idempotent I/O space is refused first. After that, the granted rights must cover what the access needs. Only when protection passes is the entry's reference/change state examined. At most one cause bit is reported per request. A request is taken when `in_valid_i` is high, and its result appears one cycle later together with `out_valid_o`.

Top module: `pgperm_check`

## Requirements
- R1: When the attribute field `pte_i[5:4]` equals 2'b10 (non-idempotent I/O) and the access is a fetch, the result has the guard cause (`cause_o` = 3'b001) and `prot_fault_o` = 1. This check comes before every other check, whatever rights are granted.
- R2: When the check is process-scoped (`part_scope_i` = 0), the privileged-page bit `pte_i[3]` is 1 and `prob_state_i` = 1, `grant_o` is 3'b000.
- R3: Outside the R2 case, when `priv_idx_i`, `pte_i[3]` or `part_scope_i` is 1, `grant_o` equals the entry's authority bits. The bits map as read = `pte_i[2]`, write = `pte_i[1]`, execute = `pte_i[0]`, and `grant_o` uses read = bit 0, write = bit 1, execute = bit 2.
- R4: In the remaining case (privileged index off, page not privileged, process-scoped), `grant_o` is the entry's authority bits ANDed with `amr_mask_i`. `amr_mask_i` uses the same bit order as `grant_o`.
- R5: The access codes are load = 0, store = 1, fetch = 2, and code 3 behaves as a load. A load needs read, a store needs write and a fetch needs execute. If the needed right is missing from `grant_o`, `prot_fault_o` = 1. The cause is guard (3'b001) for a fetch and protection (3'b010) for a load or store.
- R6: Once protection passes, a store needs both the change bit `pte_i[7]` and the reference bit `pte_i[8]`. A load or fetch needs only `pte_i[8]`. If the needed bit is missing, `rc_fault_o` = 1 and `cause_o` = 3'b100.
- R7: `rc_fault_o` and `prot_fault_o` are never both 1. `cause_o` has at most one bit set. When no fault occurs, `cause_o` is 0.
- R8: `out_valid_o` is high in the cycle after each cycle in which `in_valid_i` is high. While `in_valid_i` is low, the result outputs keep the last result and ignore changes on the other inputs.
- R9: After reset, `out_valid_o`, `grant_o`, `prot_fault_o`, `rc_fault_o` and `cause_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe; the inputs are sampled while it is high |
| pte_i | input | 64 | Leaf translation entry |
| access_i | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 treated as a load |
| prob_state_i | input | 1 | Requester is in problem (user) state |
| priv_idx_i | input | 1 | Access runs under a privileged translation index |
| part_scope_i | input | 1 | Check belongs to the partition-scoped stage |
| amr_mask_i | input | 3 | Rights allowed by the authority mask register (bit 0 read, bit 1 write, bit 2 execute) |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| grant_o | output | 3 | Granted rights (bit 0 read, bit 1 write, bit 2 execute) |
| prot_fault_o | output | 1 | Access refused by the I/O guard or by protection |
| rc_fault_o | output | 1 | Reference/change state not suitable for the access |
| cause_o | output | 3 | Cause: bit 0 guard no-execute, bit 1 protection, bit 2 atomic R/C |

## Verification
The hardest cases to reach are the ones where two rules compete. A fetch from I/O space that also lacks execute rights and has the reference bit clear must report only the guard cause. A store that protection refuses must not also report the change bit that is clear. The directed cases build these entries bit by bit. A random stream then mixes attribute codes, scope flags and masks so that every precedence path is taken many times. Idle gaps with random inputs between requests show that the outputs hold.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_W = 3;
  localparam int PERM_R = 0;
  localparam int PERM_W_BIT = 1;
  localparam int PERM_X = 2;

  localparam int CAUSE_W = 3;
  localparam int CAUSE_GUARD = 0;
  localparam int CAUSE_PROT = 1;
  localparam int CAUSE_RC = 2;

  typedef struct packed {
    logic [PERM_W-1:0]  grant;
    logic               prot_fault;
    logic               rc_fault;
    logic [CAUSE_W-1:0] cause;
  } chk_res_t;
endpackage

// File: rtl/pgperm_auth.sv
module pgperm_auth
  import pgperm_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int EAA_LSB = 0,
  parameter int PRIV_BIT = 3
) (
  input  logic [PTE_W-1:0]  pte_i,
  input  logic              prob_state_i,
  input  logic              priv_idx_i,
  input  logic              part_scope_i,
  input  logic [PERM_W-1:0] amr_mask_i,
  output logic [PERM_W-1:0] grant_o
);
  localparam int EAA_MSB = EAA_LSB + PERM_W - 1;

  logic [PERM_W-1:0] eaa;
  logic              priv_pg;

  // entry authority is stored msb=read .. lsb=exec; flip into perm order
  for (genvar i = 0; i < PERM_W; i++) begin : g_eaa
    assign eaa[i] = pte_i[EAA_MSB - i];
  end

  assign priv_pg = pte_i[PRIV_BIT];

  always_comb begin
    if (!part_scope_i && priv_pg && prob_state_i)
      grant_o = '0;
    else if (priv_idx_i || priv_pg || part_scope_i)
      grant_o = eaa;
    else
      grant_o = eaa & amr_mask_i;
  end
endmodule

// File: rtl/pgperm_rc.sv
module pgperm_rc
  import pgperm_pkg::*;
(
  input  acc_e acc_i,
  input  logic ref_i,
  input  logic chg_i,
  output logic rc_bad_o
);
  always_comb begin
    unique case (acc_i)
      ACC_STORE: rc_bad_o = !(ref_i && chg_i);
      default:   rc_bad_o = !ref_i;
    endcase
  end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
  import pgperm_pkg::*;
#(
  parameter int PTE_W = 64,
  parameter int EAA_LSB = 0,
  parameter int PRIV_BIT = 3,
  parameter int ATT_LSB = 4,
  parameter int CHG_BIT = 7,
  parameter int REF_BIT = 8,
  parameter logic [1:0] NI_IO_CODE = 2'b10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [PTE_W-1:0]   pte_i,
  input  logic [1:0]         access_i,
  input  logic               prob_state_i,
  input  logic               priv_idx_i,
  input  logic               part_scope_i,
  input  logic [PERM_W-1:0]  amr_mask_i,
  output logic               out_valid_o,
  output logic [PERM_W-1:0]  grant_o,
  output logic               prot_fault_o,
  output logic               rc_fault_o,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam int ATT_MSB = ATT_LSB + 1;

  acc_e              acc;
  logic [PERM_W-1:0] grant;
  logic [PERM_W-1:0] need;
  logic              ni_fetch, miss, rc_bad;
  chk_res_t          res_d, res_q;
  logic              vld_q;

  assign acc = acc_e'(access_i);

  pgperm_auth #(
    .PTE_W(PTE_W), .EAA_LSB(EAA_LSB), .PRIV_BIT(PRIV_BIT)
  ) i_auth (
    .pte_i(pte_i),
    .prob_state_i(prob_state_i),
    .priv_idx_i(priv_idx_i),
    .part_scope_i(part_scope_i),
    .amr_mask_i(amr_mask_i),
    .grant_o(grant)
  );

  pgperm_rc i_rc (
    .acc_i(acc),
    .ref_i(pte_i[REF_BIT]),
    .chg_i(pte_i[CHG_BIT]),
    .rc_bad_o(rc_bad)
  );

  always_comb begin
    need = '0;
    unique case (acc)
      ACC_STORE: need[PERM_W_BIT] = 1'b1;
      ACC_FETCH: need[PERM_X] = 1'b1;
      default:   need[PERM_R] = 1'b1;
    endcase
  end

  assign ni_fetch = (pte_i[ATT_MSB:ATT_LSB] == NI_IO_CODE) && (acc == ACC_FETCH);
  assign miss     = |(need & ~grant);

  // precedence: io guard, then protection, then ref/change
  always_comb begin
    res_d = '0;
    res_d.grant = grant;
    if (ni_fetch) begin
      res_d.prot_fault = 1'b1;
      res_d.cause[CAUSE_GUARD] = 1'b1;
    end else if (miss) begin
      res_d.prot_fault = 1'b1;
      if (acc == ACC_FETCH) res_d.cause[CAUSE_GUARD] = 1'b1;
      else                  res_d.cause[CAUSE_PROT] = 1'b1;
    end else if (rc_bad) begin
      res_d.rc_fault = 1'b1;
      res_d.cause[CAUSE_RC] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid_i;
      if (in_valid_i) res_q <= res_d;
    end
  end

  assign out_valid_o  = vld_q;
  assign grant_o      = res_q.grant;
  assign prot_fault_o = res_q.prot_fault;
  assign rc_fault_o   = res_q.rc_fault;
  assign cause_o      = res_q.cause;

  a_r1_io_fetch_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && pte_i[ATT_MSB:ATT_LSB] == NI_IO_CODE && access_i == 2'd2
    |=> cause_o == 3'b001 && prot_fault_o);

  a_r2_user_priv_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !part_scope_i && pte_i[PRIV_BIT] && prob_state_i
    |=> grant_o == '0);

  a_r7_single_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cause_o) && !(rc_fault_o && prot_fault_o));

  a_r7_cause_iff_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_o != '0) == (prot_fault_o || rc_fault_o));

  a_r8_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);

  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(res_q));
endmodule

// File: tb/test_pgperm_check.sv
module test_pgperm_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] pte = '0;
  logic [1:0]  acc = '0;
  logic        prob = 1'b0, pidx = 1'b0, part = 1'b0;
  logic [2:0]  amr = '0;
  logic        out_valid, prot_f, rc_f;
  logic [2:0]  grant, cause;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic [2:0] grant;
    logic       prot;
    logic       rc;
    logic [2:0] cause;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t last;
  bit   have_last = 0;

  always #10 clk = ~clk;

  pgperm_check i_pgperm_check (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .pte_i(pte),
    .access_i(acc), .prob_state_i(prob), .priv_idx_i(pidx),
    .part_scope_i(part), .amr_mask_i(amr), .out_valid_o(out_valid),
    .grant_o(grant), .prot_fault_o(prot_f), .rc_fault_o(rc_f), .cause_o(cause)
  );

  function automatic exp_t model(logic [63:0] e, logic [1:0] a, logic pr,
                                 logic pi, logic pt, logic [2:0] m);
    exp_t r;
    logic [2:0] auth;
    logic [2:0] nd;
    logic ok_rc;
    auth = {e[0], e[1], e[2]};
    r.prot = 0; r.rc = 0; r.cause = 0;
    if (!pt && e[3] && pr) begin r.grant = 0; r.tag = "R2"; end
    else if (pi || e[3] || pt) begin r.grant = auth; r.tag = "R3"; end
    else begin r.grant = auth & m; r.tag = "R4"; end
    nd = (a == 2'd1) ? 3'b010 : (a == 2'd2) ? 3'b100 : 3'b001;
    ok_rc = (a == 2'd1) ? (e[8] & e[7]) : e[8];
    if (e[5:4] == 2'b10 && a == 2'd2) begin
      r.prot = 1; r.cause = 3'b001; r.tag = "R1";
    end else if ((nd & ~r.grant) != 0) begin
      r.prot = 1; r.cause = (a == 2'd2) ? 3'b001 : 3'b010; r.tag = "R5";
    end else if (!ok_rc) begin
      r.rc = 1; r.cause = 3'b100; r.tag = "R6";
    end
    return r;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic send(logic [63:0] e, logic [1:0] a, logic pr, logic pi,
                      logic pt, logic [2:0] m, string force_tag = "");
    exp_t x;
    @(negedge clk);
    pte = e; acc = a; prob = pr; pidx = pi; part = pt; amr = m; in_valid = 1;
    x = model(e, a, pr, pi, pt, m);
    if (force_tag != "") x.tag = force_tag;
    q.push_back(x);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
      pte = {$urandom, $urandom}; acc = 2'($urandom); amr = 3'($urandom);
      prob = 1'($urandom); pidx = 1'($urandom); part = 1'($urandom);
    end
  endtask

  // monitor: sample a quarter period after the edge
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      if (out_valid) begin
        if (q.size() == 0) check("R8", "unexpected out_valid", 1, 0);
        else begin
          exp_t x;
          x = q.pop_front();
          check(x.tag, "grant", grant, x.grant);
          check(x.tag, "prot_fault", prot_f, x.prot);
          check(x.tag, "rc_fault", rc_f, x.rc);
          check(x.tag, "cause", cause, x.cause);
          check("R7", "single cause", $countones(cause) <= 1, 1);
          last = x; have_last = 1;
        end
      end else if (have_last) begin
        check("R8", "held result", {grant, prot_f, rc_f, cause},
              {last.grant, last.prot, last.rc, last.cause});
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  localparam logic [63:0] RC_OK = 64'h180;  // ref + change

  initial begin
    #5;
    check("R9", "reset outputs", {out_valid, grant, prot_f, rc_f, cause}, 0);
    repeat (2) @(negedge clk);
    check("R9", "reset outputs held", {out_valid, grant, prot_f, rc_f, cause}, 0);
    rst_n = 1;

    // R1: io fetch with execute granted and with nothing granted, ref clear
    send(64'h20 | 64'h7 | RC_OK, 2'd2, 0, 1, 0, 3'b111, "R1");
    send(64'h20, 2'd2, 0, 0, 0, 3'b000, "R1");
    send(64'h20 | 64'h7 | RC_OK, 2'd0, 0, 0, 0, 3'b111); // io load is fine
    // R2: user on privileged page, process scope
    send(64'h8 | 64'h7 | RC_OK, 2'd0, 1, 0, 0, 3'b111, "R2");
    send(64'h8 | 64'h7 | RC_OK, 2'd0, 1, 0, 1, 3'b000, "R3"); // partition
    // R3: privileged index bypasses mask
    send(64'h6 | RC_OK, 2'd1, 0, 1, 0, 3'b000, "R3");
    // R4: mask removes write
    send(64'h6 | RC_OK, 2'd1, 0, 0, 0, 3'b001, "R4");
    send(64'h6 | RC_OK, 2'd0, 0, 0, 0, 3'b001, "R4");
    // R5: fetch without execute -> guard; code 3 acts as load
    send(64'h4 | RC_OK, 2'd2, 0, 1, 0, 3'b111, "R5");
    send(64'h2 | RC_OK, 2'd3, 0, 1, 0, 3'b111, "R5");
    // R6: store missing change, load with ref only
    send(64'h6 | 64'h100, 2'd1, 0, 1, 0, 3'b111, "R6");
    send(64'h4 | 64'h100, 2'd0, 0, 1, 0, 3'b111, "R6");
    send(64'h1 | 64'h080, 2'd2, 0, 1, 0, 3'b111, "R6");
    // R7: store refused with change clear -> protection only
    send(64'h4, 2'd1, 0, 1, 0, 3'b111, "R7");
    idle(3);  // R8 hold under noisy inputs
    for (int i = 0; i < 400; i++) begin
      logic [63:0] e;
      e = {$urandom, $urandom};
      send(e, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(3);
    check("R8", "queue drained", q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule